// File: doc/BRIEF.md
# Three-Mode General-Purpose Timer Bank

This block holds a small bank of independent 32-bit timers. Each timer owns a 6-bit configuration word, a count register, a period register and a width register. It works on a single pin that it either drives or samples. A timer can run in one of three modes:

- Waveform mode drives a periodic pulse train on the pin.
- Capture mode measures the high (or low) time and the repeat time of a pulse train arriving on the pin.
- Watchdog mode counts cycles since the last event on the pin and flags when an event is overdue.

One shared control word turns each timer on or off on its own and holds one sticky event flag per timer. Writing a one to a flag clears it. Software reaches every register through a plain write port and a combinational read port. The pin is split into an input, an output value and an output enable, so a pad cell can be placed outside the block. Each timer drives one interrupt line. That line is high while its event flag is set and its interrupt-enable bit is on.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every register reads zero, every `pin_oe` and `pin_o` bit is 0 and every `irq` bit is 0.
- R2: Register map: timer t uses address 4t+0 for configuration, 4t+1 for count, 4t+2 for period and 4t+3 for width. The control word is at address 4N: bits [N-1:0] are the timer enables and bits [2N-1:N] are the event flags. Configuration stores 6 bits and reads back zero-extended. Unused address space reads zero.
- R3: Configuration bits [1:0] select the mode: 01 waveform, 10 capture, 11 watchdog, 00 off. Bit 2 is polarity, bit 3 is interrupt enable, bit 4 selects the capture report and bit 5 is stored with no effect. In waveform mode with the timer enabled, `pin_oe` is 1 and the count goes 1, 2, … up to the period value and then back to 1. The pin is active while 1 ≤ count ≤ width. The output is high when active with polarity 0, and inverted with polarity 1.
- R4: In waveform mode an event fires on each cycle in which the count is at or above the period value. That is the cycle in which the count wraps.
- R5: In capture mode the pin passes through two input flops before edges are judged. The leading edge is rising with polarity 0 and falling with polarity 1. On a leading edge the count restarts at 1, and the count reached is copied into the period register. No copy happens on the first leading edge after the timer is enabled or configured. On a trailing edge the count reached is copied into the width register. The result is pulse length and repeat time in clock cycles.
- R6: In capture mode with bit 4 clear, an event fires on each width capture. With bit 4 set, an event fires on each period capture only.
- R7: In watchdog mode a leading edge on the pin resets the count to 0. Otherwise the count rises by one per cycle until it is at or above the period value. In that cycle an event fires and the count returns to 0.
- R8: An event sets its timer's flag. Writing 1 to a flag bit clears it, but an event in the same cycle wins. `irq[t]` equals flag t AND configuration bit 3 of timer t.
- R9: A disabled timer keeps its count, drives `pin_oe` low, raises no events and is re-armed so that its next capture skips the period copy.
- R10: An enabled timer in mode 00 keeps its count and leaves the pin as an input.
- R11: A software write to a timer's count, period or width register takes effect over any hardware update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | CW | Combinational read data |
| pin_i | input | N | Pin input value per timer |
| pin_o | output | N | Pin drive value per timer |
| pin_oe | output | N | Pin output enable per timer |
| irq | output | N | Interrupt line per timer |

## Verification
Two pairs of functions can meet in one cycle:

- A software write-one-to-clear of an event flag and a fresh hardware event on the same timer. The bench provokes this with a waveform period of 0, which makes every cycle a wrap. It then reads the control word after the clearing write and expects the flag to still be set. A later clear with a long period must take effect.
- A software count write and the hardware increment. The bench writes the count while the timer is running and reads the written value back in the very next cycle.

A behavioural model, stepped every clock, judges the pins, interrupts and read data throughout.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CFG_W       = 6;
  localparam int REG_PER_TMR = 4;
  localparam int OFS_CFG     = 0;
  localparam int OFS_CNT     = 1;
  localparam int OFS_PER     = 2;
  localparam int OFS_WID     = 3;
  localparam int CFG_IRQ_BIT = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_WAVE = 2'b01,
    MODE_CAPT = 2'b10,
    MODE_WDOG = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      rsvd;
    logic      rpt_per;
    logic      irq_en;
    logic      pol;
    tmr_mode_e mode;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_edge.sv
`timescale 1ns/1ps
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol,
  output logic lead,
  output logic trail
);
  logic s1_q, s2_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign rise  = s1_q & ~s2_q;
  assign fall  = ~s1_q & s2_q;
  assign lead  = pol ? fall : rise;
  assign trail = pol ? rise : fall;
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core import tmr_pkg::*; #(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_we,
  input  logic             cnt_we,
  input  logic             per_we,
  input  logic             wid_we,
  input  logic [CW-1:0]    wdata,
  input  logic             pin_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    per_o,
  output logic [CW-1:0]    wid_o,
  output logic             pin_o,
  output logic             pin_oe,
  output logic             evt_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  tmr_cfg_t      cfg_q, cfg_n;
  logic [CW-1:0] cnt_q, cnt_n, per_q, per_n, wid_q, wid_n;
  logic          first_q, first_n;
  logic          lead, trail, evt_c, active;

  tmr_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .pol   (cfg_q.pol),
    .lead  (lead),
    .trail (trail)
  );

  always_comb begin
    cfg_n   = cfg_q;
    cnt_n   = cnt_q;
    per_n   = per_q;
    wid_n   = wid_q;
    first_n = first_q;
    evt_c   = 1'b0;
    if (en) begin
      unique case (cfg_q.mode)
        MODE_WAVE: begin
          if (cnt_q >= per_q) begin
            cnt_n = ONE;
            evt_c = 1'b1;
          end else begin
            cnt_n = cnt_q + ONE;
          end
        end
        MODE_CAPT: begin
          if (lead) begin
            cnt_n   = ONE;
            first_n = 1'b0;
            if (!first_q) begin
              per_n = cnt_q;
              evt_c = cfg_q.rpt_per;
            end
          end else begin
            cnt_n = cnt_q + ONE;
            if (trail) begin
              wid_n = cnt_q;
              evt_c = ~cfg_q.rpt_per;
            end
          end
        end
        MODE_WDOG: begin
          if (lead) begin
            cnt_n = '0;
          end else if (cnt_q >= per_q) begin
            cnt_n = '0;
            evt_c = 1'b1;
          end else begin
            cnt_n = cnt_q + ONE;
          end
        end
        default: ;
      endcase
    end else begin
      first_n = 1'b1;
    end
    // software writes take priority over hardware updates
    if (cfg_we) begin
      cfg_n   = tmr_cfg_t'(wdata[CFG_W-1:0]);
      first_n = 1'b1;
    end
    if (cnt_we) cnt_n = wdata;
    if (per_we) per_n = wdata;
    if (wid_we) wid_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cnt_q   <= '0;
      per_q   <= '0;
      wid_q   <= '0;
      first_q <= 1'b1;
    end else begin
      cfg_q   <= cfg_n;
      cnt_q   <= cnt_n;
      per_q   <= per_n;
      wid_q   <= wid_n;
      first_q <= first_n;
    end
  end

  assign active = (cnt_q != '0) && (cnt_q <= wid_q);
  assign pin_oe = en && (cfg_q.mode == MODE_WAVE);
  assign pin_o  = pin_oe ? (active ^ cfg_q.pol) : 1'b0;
  assign evt_o  = evt_c;
  assign cfg_o  = cfg_q;
  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign wid_o  = wid_q;
endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [2*N-1:0] ctrl_wdata,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] en_o,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] en_q, stat_q, clr;

  assign clr = ctrl_we ? ctrl_wdata[2*N-1:N] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (ctrl_we) en_q <= ctrl_wdata[N-1:0];
      stat_q <= (stat_q & ~clr) | evt;
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign irq_o  = stat_q & irq_en;
endmodule

// File: rtl/gp_timer_bank.sv
`timescale 1ns/1ps
module gp_timer_bank import tmr_pkg::*; #(
  parameter int  N  = 2,
  parameter int  CW = 32,
  localparam int AW = $clog2(N*REG_PER_TMR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic [N-1:0]  pin_i,
  output logic [N-1:0]  pin_o,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  irq
);
  localparam int CTRL_ADDR = N*REG_PER_TMR;

  logic [N-1:0]            en_q, stat_q, evt_v, irq_en_v;
  logic [N-1:0][CW-1:0]    cnt_v, per_v, wid_v;
  logic [N-1:0][CFG_W-1:0] cfg_v;
  logic                    ctrl_we;

  assign ctrl_we = wr_en && (wr_addr == AW'(CTRL_ADDR));

  for (genvar t = 0; t < N; t++) begin : g_tmr
    logic cfg_we, cnt_we, per_we, wid_we;
    assign cfg_we = wr_en && (wr_addr == AW'(t*REG_PER_TMR + OFS_CFG));
    assign cnt_we = wr_en && (wr_addr == AW'(t*REG_PER_TMR + OFS_CNT));
    assign per_we = wr_en && (wr_addr == AW'(t*REG_PER_TMR + OFS_PER));
    assign wid_we = wr_en && (wr_addr == AW'(t*REG_PER_TMR + OFS_WID));
    assign irq_en_v[t] = cfg_v[t][CFG_IRQ_BIT];

    tmr_core #(.CW(CW)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_q[t]),
      .cfg_we (cfg_we),
      .cnt_we (cnt_we),
      .per_we (per_we),
      .wid_we (wid_we),
      .wdata  (wr_data),
      .pin_i  (pin_i[t]),
      .cfg_o  (cfg_v[t]),
      .cnt_o  (cnt_v[t]),
      .per_o  (per_v[t]),
      .wid_o  (wid_v[t]),
      .pin_o  (pin_o[t]),
      .pin_oe (pin_oe[t]),
      .evt_o  (evt_v[t])
    );
  end

  tmr_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (wr_data[2*N-1:0]),
    .evt        (evt_v),
    .irq_en     (irq_en_v),
    .en_o       (en_q),
    .stat_o     (stat_q),
    .irq_o      (irq)
  );

  always_comb begin
    rd_data = '0;
    for (int t = 0; t < N; t++) begin
      if (rd_addr == AW'(t*REG_PER_TMR + OFS_CFG)) rd_data = CW'(cfg_v[t]);
      if (rd_addr == AW'(t*REG_PER_TMR + OFS_CNT)) rd_data = cnt_v[t];
      if (rd_addr == AW'(t*REG_PER_TMR + OFS_PER)) rd_data = per_v[t];
      if (rd_addr == AW'(t*REG_PER_TMR + OFS_WID)) rd_data = wid_v[t];
    end
    if (rd_addr == AW'(CTRL_ADDR)) rd_data = CW'({stat_q, en_q});
  end
endmodule

// File: rtl/tmr_bank_chk.sv
`timescale 1ns/1ps
module tmr_bank_chk #(
  parameter int  N  = 2,
  parameter int  CW = 32,
  localparam int AW = $clog2(N*4 + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [AW-1:0]       wr_addr,
  input logic [CW-1:0]       wr_data,
  input logic [N-1:0]        pin_oe,
  input logic [N-1:0]        irq,
  input logic [N-1:0]        en_q,
  input logic [N-1:0]        stat_q,
  input logic [N-1:0]        evt_v,
  input logic [N-1:0][CW-1:0] cnt_v,
  input logic [N-1:0][CW-1:0] per_v,
  input logic [N-1:0][5:0]   cfg_v
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == AW'(N*4));

  for (genvar t = 0; t < N; t++) begin : g_chk
    logic cnt_wr, is_wave, is_wdog;
    assign cnt_wr  = wr_en && (wr_addr == AW'(t*4 + 1));
    assign is_wave = en_q[t] && (cfg_v[t][1:0] == 2'b01);
    assign is_wdog = cfg_v[t][1:0] == 2'b11;

    assert_wave_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wave && (cnt_v[t] >= per_v[t]) && !cnt_wr) |=> (cnt_v[t] == CW'(1)));

    assert_wave_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wave && (cnt_v[t] >= per_v[t])) |-> evt_v[t]);

    assert_wdog_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_v[t] && is_wdog) |-> (cnt_v[t] >= per_v[t]));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_v[t] |=> stat_q[t]);

    assert_flag_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[N+t] && !evt_v[t]) |=> !stat_q[t]);

    assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[t] |-> stat_q[t]);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[t] && !cnt_wr) |=> $stable(cnt_v[t]));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[t] |-> (!pin_oe[t] && !evt_v[t]));
  end
endmodule

bind gp_timer_bank tmr_bank_chk #(.N(N), .CW(CW)) u_chk (.*);

// File: tb/gp_timer_bank_bench.sv
`timescale 1ns/1ps
module gp_timer_bank_bench;
  localparam int N = 2;
  localparam int CW = 32;
  localparam int AW = 4;
  localparam int CTRL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] pin_o, pin_oe, irq;

  int n_tests = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;

  always #2.5 clk = ~clk;

  gp_timer_bank #(.N(N), .CW(CW)) u_gp_timer_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference model
  logic [5:0]  m_cfg [N];
  logic [31:0] m_cnt [N];
  logic [31:0] m_per [N];
  logic [31:0] m_wid [N];
  logic        m_first [N];
  logic        m_s1 [N];
  logic        m_s2 [N];
  logic [N-1:0] m_en, m_stat;

  task automatic model_reset();
    for (int t = 0; t < N; t++) begin
      m_cfg[t] = '0; m_cnt[t] = '0; m_per[t] = '0; m_wid[t] = '0;
      m_first[t] = 1'b1; m_s1[t] = 1'b0; m_s2[t] = 1'b0;
    end
    m_en = '0; m_stat = '0;
  endtask

  task automatic model_step();
    logic [N-1:0] ev;
    logic [N-1:0] clr;
    ev = '0;
    for (int t = 0; t < N; t++) begin
      logic pol, lead, trail, nf;
      logic [31:0] nc, np, nw;
      logic [5:0] ncfg;
      pol   = m_cfg[t][2];
      lead  = pol ? (!m_s1[t] && m_s2[t]) : (m_s1[t] && !m_s2[t]);
      trail = pol ? (m_s1[t] && !m_s2[t]) : (!m_s1[t] && m_s2[t]);
      nc = m_cnt[t]; np = m_per[t]; nw = m_wid[t]; nf = m_first[t]; ncfg = m_cfg[t];
      if (m_en[t]) begin
        case (m_cfg[t][1:0])
          2'b01: if (m_cnt[t] >= m_per[t]) begin nc = 1; ev[t] = 1'b1; end
                 else nc = m_cnt[t] + 1;
          2'b10: if (lead) begin
                   nc = 1; nf = 1'b0;
                   if (!m_first[t]) begin np = m_cnt[t]; ev[t] = m_cfg[t][4]; end
                 end else begin
                   nc = m_cnt[t] + 1;
                   if (trail) begin nw = m_cnt[t]; ev[t] = !m_cfg[t][4]; end
                 end
          2'b11: if (lead) nc = 0;
                 else if (m_cnt[t] >= m_per[t]) begin nc = 0; ev[t] = 1'b1; end
                 else nc = m_cnt[t] + 1;
          default: ;
        endcase
      end else begin
        nf = 1'b1;
      end
      if (wr_en && wr_addr == AW'(t*4))     begin ncfg = wr_data[5:0]; nf = 1'b1; end
      if (wr_en && wr_addr == AW'(t*4 + 1)) nc = wr_data;
      if (wr_en && wr_addr == AW'(t*4 + 2)) np = wr_data;
      if (wr_en && wr_addr == AW'(t*4 + 3)) nw = wr_data;
      m_cfg[t] = ncfg; m_cnt[t] = nc; m_per[t] = np; m_wid[t] = nw; m_first[t] = nf;
      m_s2[t] = m_s1[t]; m_s1[t] = pin_i[t];
    end
    clr = (wr_en && wr_addr == AW'(CTRL)) ? wr_data[2*N-1:N] : '0;
    m_stat = (m_stat & ~clr) | ev;
    if (wr_en && wr_addr == AW'(CTRL)) m_en = wr_data[N-1:0];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  function automatic logic exp_oe(int t);
    return m_en[t] && (m_cfg[t][1:0] == 2'b01);
  endfunction

  function automatic logic exp_po(int t);
    logic act;
    act = (m_cnt[t] != 0) && (m_cnt[t] <= m_wid[t]);
    return exp_oe(t) ? (act ^ m_cfg[t][2]) : 1'b0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    logic [31:0] v;
    v = '0;
    for (int t = 0; t < N; t++) begin
      if (a == AW'(t*4))     v = {26'd0, m_cfg[t]};
      if (a == AW'(t*4 + 1)) v = m_cnt[t];
      if (a == AW'(t*4 + 2)) v = m_per[t];
      if (a == AW'(t*4 + 3)) v = m_wid[t];
    end
    if (a == AW'(CTRL)) v = {28'd0, m_stat, m_en};
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && run_cmp) begin
      for (int t = 0; t < N; t++) begin
        chk($sformatf("R3 pin_oe/pin_o timer %0d", t),
            {30'd0, pin_oe[t], pin_o[t]}, {30'd0, exp_oe(t), exp_po(t)});
        chk($sformatf("R8 irq timer %0d", t), {31'd0, irq[t]},
            {31'd0, m_stat[t] && m_cfg[t][3]});
      end
      chk($sformatf("R2 rd_data addr %0d", rd_addr), rd_data, exp_rd(rd_addr));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = AW'(a);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic rdval(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = AW'(a);
    #1;
    v = rd_data;
  endtask

  task automatic pulse(input int t, input int hi, input int lo);
    @(negedge clk);
    pin_i[t] = 1'b1;
    repeat (hi) @(negedge clk);
    pin_i[t] = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic count_high(input int t, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pin_o[t]) n++;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v1, v2;
    int nh;
    // R1: reset state
    repeat (3) @(negedge clk);
    rd_addr = AW'(CTRL); #1;
    chk("R1 ctrl after reset", rd_data, 32'h0);
    chk("R1 pin_oe/irq after reset", {28'd0, pin_oe, irq}, 32'h0);
    rd_addr = AW'(1); #1;
    chk("R1 count after reset", rd_data, 32'h0);
    rst_n = 1'b1;
    run_cmp = 1'b1;

    // R2: configuration stores 6 bits
    wr(0, 32'hFF);
    rdchk(0, 32'h3F, "R2 cfg readback width");
    rdchk(9, 32'h0, "R2 unused address");

    // R3/R4: waveform, period 4, width 1
    wr(0, 32'h09); wr(2, 4); wr(3, 1); wr(1, 0);
    wr(CTRL, 32'h1);
    count_high(0, 8, nh);
    chk("R3 active cycles per 8 (pol 0)", nh, 2);
    chk("R3 pin_oe in waveform", {31'd0, pin_oe[0]}, 32'h1);
    rdchk(CTRL, 32'h5, "R4 wrap event flag");
    chk("R8 irq with enable bit", {31'd0, irq[0]}, 32'h1);
    wr(0, 32'h0D);
    count_high(0, 8, nh);
    chk("R3 active cycles per 8 (pol 1)", nh, 6);

    // R8: clear and event in the same cycle (period 0 wraps every cycle)
    wr(0, 32'h09); wr(2, 0); wr(3, 1);
    wr(CTRL, 32'h5);
    rdchk(CTRL, 32'h5, "R8 event wins over clear");
    wr(2, 1000);
    wr(CTRL, 32'h5);
    rdchk(CTRL, 32'h1, "R8 W1C clears flag");
    chk("R8 irq low after clear", {31'd0, irq[0]}, 32'h0);

    // R9: disable freezes count and releases pin
    wr(CTRL, 32'h0);
    rdval(1, v1);
    repeat (5) @(negedge clk);
    rdval(1, v2);
    chk("R9 count frozen while disabled", v2, v1);
    chk("R9 pin released", {31'd0, pin_oe[0]}, 32'h0);

    // R11: software count write over hardware increment
    wr(CTRL, 32'h1);
    rd_addr = AW'(1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(1); wr_data = 32'd100;
    @(posedge clk); #1;
    chk("R11 count write wins", rd_data, 32'd100);
    @(negedge clk); wr_en = 1'b0;

    // R10: mode off keeps count, pin is input
    wr(0, 32'h00);
    rdval(1, v1);
    repeat (4) @(negedge clk);
    rdval(1, v2);
    chk("R10 count held in mode 00", v2, v1);
    chk("R10 pin input in mode 00", {31'd0, pin_oe[0]}, 32'h0);
    wr(CTRL, 32'h0);

    // R5: capture on timer 1, width events
    wr(4, 32'h0A);
    wr(CTRL, 32'h2);
    pulse(1, 3, 5);
    repeat (3) @(negedge clk);
    rdchk(6, 32'd0, "R5 first leading edge skips period");
    rdchk(7, 32'd3, "R5 width after one pulse");
    pulse(1, 3, 5); pulse(1, 3, 5); pulse(1, 3, 5);
    rdchk(6, 32'd8, "R5 period capture");
    rdchk(7, 32'd3, "R5 width capture");
    rdchk(CTRL, 32'hA, "R6 width event with bit4 clear");

    // R6: report on period only
    wr(4, 32'h1A);
    wr(CTRL, 32'hA);
    pulse(1, 2, 6);
    rdchk(CTRL, 32'h2, "R6 no event on width or first edge");
    pulse(1, 2, 6);
    rdchk(CTRL, 32'hA, "R6 event on period capture");

    // R7: watchdog on timer 1, period 6
    wr(4, 32'h0B); wr(6, 6); wr(5, 0);
    wr(CTRL, 32'hA);
    for (int i = 0; i < 4; i++) pulse(1, 1, 4);
    rdchk(CTRL, 32'h2, "R7 no event while edges arrive");
    repeat (12) @(negedge clk);
    rdchk(CTRL, 32'hA, "R7 event when edges stop");
    chk("R7 irq on watchdog", {31'd0, irq[1]}, 32'h1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule